// File: doc/BRIEF.md
# Strided DMA Register Controller

This block is a register-programmed DMA engine that moves data between an external memory and a local scratch memory in 8-byte beats. One transfer is a rectangle: a number of rows of equal size, where the external side jumps over a gap after each row and the local side stays packed. Software programs an external address, a local address and a shape word. Which trigger register it writes selects the direction.

A single pending slot sits behind the active transfer, so software can queue the next job while the current one runs. Two status bits report whether the engine is busy and whether the slot is taken.

On the external side, the engine raises a request with an address and moves one beat per cycle in which the grant is high. On the local side, it gives a per-beat read or write strobe. The data paths are straight wires between the two memories.

Top module: `strided_dma`

## Requirements
- R1: After reset, extReq, locWrEn and locRdEn are low, and all register reads return zero.
- R2: A write to offset 0 (external address) or offset 1 (local address) stores the data with bits 2:0 cleared. That value reads back on regRdData while regAddr selects the same offset.
- R3: Offset 4 reads the status word. Bit 2 is set while a transfer is active or pending, and bit 3 is set while the pending slot is full. All other bits read zero, and reading has no side effect. Offsets 2, 3, 5, 6 and 7 read zero.
- R4: The shape word carries skip in bits 31:20, count in bits 19:12 and length in bits 11:0. Writing it to offset 2 starts an external-to-local transfer (extWrite low). Writing it to offset 3 starts a local-to-external transfer (extWrite high).
- R5: When the engine is idle, a trigger makes extReq high in the next cycle. extAddr and locAddr then show the programmed addresses.
- R6: Each beat in which extReq and extGrant are both high moves 8 bytes, and both addresses advance by 8. A row has (length >> 3) + 1 beats, so length bits 2:0 have no effect.
- R7: A transfer has count + 1 rows. The next row's external address is the previous row's start, plus the row size in bytes, plus skip with bits 2:0 cleared. The local address stays contiguous across rows.
- R8: For external-to-local transfers, locWrEn is high exactly in granted beats and locWrData equals extRdData. For local-to-external transfers, locRdEn is high whenever extReq is high and extWrData equals locRdData.
- R9: A trigger while a transfer is active and the slot is empty queues the job, using the address registers as they are at trigger time. The full bit is set from the next cycle.
- R10: A queued job becomes active at the clock edge that ends the last beat of the current job. In the next cycle extReq stays high at the queued addresses and the full bit is clear.
- R11: A trigger while the full bit reads 1 is ignored. No transfer is ever issued for it.
- R12: After the last beat, with nothing queued, extReq and the busy bit are low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset for writes and reads |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the register at regAddr |
| extReq | output | 1 | Beat request to external memory |
| extWrite | output | 1 | 1: local-to-external, 0: external-to-local |
| extAddr | output | 32 | External byte address of the current beat |
| extGrant | input | 1 | Beat accepted this cycle |
| extRdData | input | 64 | Data from external memory |
| extWrData | output | 64 | Data to external memory |
| locAddr | output | 32 | Local byte address of the current beat |
| locWrEn | output | 1 | Local write strobe |
| locWrData | output | 64 | Local write data |
| locRdEn | output | 1 | Local read strobe |
| locRdData | input | 64 | Local read data |

## Verification
Every internal counter or address register shows up on extAddr, locAddr or extReq in the first granted beat after it goes wrong. The bench model checks those ports every cycle, so a wrong beat count, row count or skip sum is caught on the very beat where the address jumps too early or too late. A wrong pending-slot state shows at once in status bit 3. At the latest it shows at the end of the active job, as a missing or extra transfer. The contents of the local memory stub are also checked after a strided read, to confirm where each beat landed.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int REG_AW    = 3;
  localparam int REG_DW    = 32;
  localparam int BEAT_SH   = 3;
  localparam int LEN_HI    = 11;
  localparam int CNT_LO    = 12;
  localparam int CNT_HI    = 19;
  localparam int SKIP_LO   = 20;
  localparam int SKIP_HI   = 31;
  localparam int BEAT_W    = LEN_HI - BEAT_SH + 1;
  localparam int ROW_W     = CNT_HI - CNT_LO + 1;
  localparam int SKIPA_W   = SKIP_HI - SKIP_LO + 1 - BEAT_SH;
  localparam logic [REG_AW-1:0] OFS_EXT  = 3'd0;
  localparam logic [REG_AW-1:0] OFS_LOC  = 3'd1;
  localparam logic [REG_AW-1:0] OFS_GETS = 3'd2;
  localparam logic [REG_AW-1:0] OFS_PUTS = 3'd3;
  localparam logic [REG_AW-1:0] OFS_STAT = 3'd4;
  localparam int BIT_BUSY  = 2;
  localparam int BIT_FULL  = 3;

  typedef struct packed {
    logic takeNew;
    logic takePend;
    logic fillPend;
    logic stepBeat;
    logic stepRow;
    logic wrExt;
    logic wrLoc;
  } sdmaStrobeT;
endpackage

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  input  logic              extGrant,
  output sdmaStrobeT        strobe,
  output logic              actValid,
  output logic              actDir,
  output logic              pendValid,
  output logic              beatGo
);
  logic [BEAT_W-1:0] beatCnt, beatReload, pendBeats;
  logic [ROW_W-1:0]  rowCnt, pendRows;
  logic              pendDir;
  logic              trig, trigDir, rowEnd, lastBeat, freeNext;

  assign trig     = regWrEn && (regAddr == OFS_GETS || regAddr == OFS_PUTS);
  assign trigDir  = (regAddr == OFS_PUTS);
  assign beatGo   = actValid && extGrant;
  assign rowEnd   = beatGo && (beatCnt == '0);
  assign lastBeat = rowEnd && (rowCnt == '0);
  assign freeNext = !actValid || lastBeat;

  always_comb begin
    strobe          = '0;
    strobe.takeNew  = trig && freeNext && !pendValid;
    strobe.takePend = lastBeat && pendValid;
    strobe.fillPend = trig && !freeNext && !pendValid;
    strobe.stepRow  = rowEnd && !lastBeat;
    strobe.stepBeat = beatGo && !rowEnd;
    strobe.wrExt    = regWrEn && regAddr == OFS_EXT;
    strobe.wrLoc    = regWrEn && regAddr == OFS_LOC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actValid   <= 1'b0;
      actDir     <= 1'b0;
      beatCnt    <= '0;
      beatReload <= '0;
      rowCnt     <= '0;
      pendValid  <= 1'b0;
      pendDir    <= 1'b0;
      pendBeats  <= '0;
      pendRows   <= '0;
    end else begin
      if (strobe.takeNew) begin
        actValid   <= 1'b1;
        actDir     <= trigDir;
        beatCnt    <= regWrData[LEN_HI:BEAT_SH];
        beatReload <= regWrData[LEN_HI:BEAT_SH];
        rowCnt     <= regWrData[CNT_HI:CNT_LO];
      end else if (strobe.takePend) begin
        actDir     <= pendDir;
        beatCnt    <= pendBeats;
        beatReload <= pendBeats;
        rowCnt     <= pendRows;
      end else if (lastBeat) begin
        actValid   <= 1'b0;
      end else if (rowEnd) begin
        beatCnt    <= beatReload;
        rowCnt     <= rowCnt - 1'b1;
      end else if (beatGo) begin
        beatCnt    <= beatCnt - 1'b1;
      end

      if (strobe.fillPend) begin
        pendValid <= 1'b1;
        pendDir   <= trigDir;
        pendBeats <= regWrData[LEN_HI:BEAT_SH];
        pendRows  <= regWrData[CNT_HI:CNT_LO];
      end else if (strobe.takePend) begin
        pendValid <= 1'b0;
      end
    end
  end

  AST_PEND_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    pendValid |-> actValid); // R9
  AST_PROMOTE_NO_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && pendValid) |=> (actValid && !pendValid)); // R10
  AST_DRAIN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !pendValid && !trig) |=> !actValid); // R12
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (pendValid && !lastBeat) |=> (pendValid && $stable(pendBeats) && $stable(pendRows))); // R11
  AST_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (trig && !actValid) |=> actValid); // R5
endmodule

// File: rtl/sdma_path.sv
module sdma_path
  import sdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  sdmaStrobeT        strobe,
  input  logic [REG_DW-1:0] regWrData,
  output logic [ADDR_W-1:0] progExt,
  output logic [ADDR_W-1:0] progLoc,
  output logic [ADDR_W-1:0] actExt,
  output logic [ADDR_W-1:0] actLoc
);
  localparam logic [ADDR_W-1:0] BEAT_BYTES = ADDR_W'(1 << BEAT_SH);

  logic [ADDR_W-1:0]  pendExt, pendLoc;
  logic [SKIPA_W-1:0] actSkip, pendSkip;
  logic [ADDR_W-1:0]  wrAligned, skipBytes;

  assign wrAligned = ADDR_W'({regWrData[REG_DW-1:BEAT_SH], {BEAT_SH{1'b0}}});
  assign skipBytes = ADDR_W'({actSkip, {BEAT_SH{1'b0}}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progExt  <= '0;
      progLoc  <= '0;
      pendExt  <= '0;
      pendLoc  <= '0;
      pendSkip <= '0;
      actExt   <= '0;
      actLoc   <= '0;
      actSkip  <= '0;
    end else begin
      if (strobe.wrExt) progExt <= wrAligned;
      if (strobe.wrLoc) progLoc <= wrAligned;

      if (strobe.fillPend) begin
        pendExt  <= progExt;
        pendLoc  <= progLoc;
        pendSkip <= regWrData[SKIP_HI:SKIP_LO+BEAT_SH];
      end

      if (strobe.takeNew) begin
        actExt  <= progExt;
        actLoc  <= progLoc;
        actSkip <= regWrData[SKIP_HI:SKIP_LO+BEAT_SH];
      end else if (strobe.takePend) begin
        actExt  <= pendExt;
        actLoc  <= pendLoc;
        actSkip <= pendSkip;
      end else if (strobe.stepRow) begin
        actExt  <= actExt + BEAT_BYTES + skipBytes;
        actLoc  <= actLoc + BEAT_BYTES;
      end else if (strobe.stepBeat) begin
        actExt  <= actExt + BEAT_BYTES;
        actLoc  <= actLoc + BEAT_BYTES;
      end
    end
  end

  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (actExt[BEAT_SH-1:0] == '0) && (actLoc[BEAT_SH-1:0] == '0)); // R6
  AST_LOC_CONTIG: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepRow || strobe.stepBeat) |=> (actLoc == $past(actLoc) + BEAT_BYTES)); // R7
endmodule

// File: rtl/strided_dma.sv
module strided_dma
  import sdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  output logic [REG_DW-1:0] regRdData,
  output logic              extReq,
  output logic              extWrite,
  output logic [ADDR_W-1:0] extAddr,
  input  logic              extGrant,
  input  logic [DATA_W-1:0] extRdData,
  output logic [DATA_W-1:0] extWrData,
  output logic [ADDR_W-1:0] locAddr,
  output logic              locWrEn,
  output logic [DATA_W-1:0] locWrData,
  output logic              locRdEn,
  input  logic [DATA_W-1:0] locRdData
);
  sdmaStrobeT        strobe;
  logic              actValid, actDir, pendValid, beatGo;
  logic [ADDR_W-1:0] progExt, progLoc;

  sdma_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .extGrant(extGrant), .strobe(strobe),
    .actValid(actValid), .actDir(actDir), .pendValid(pendValid),
    .beatGo(beatGo));

  sdma_path #(.ADDR_W(ADDR_W)) i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrData(regWrData),
    .progExt(progExt), .progLoc(progLoc), .actExt(extAddr), .actLoc(locAddr));

  assign extReq    = actValid;
  assign extWrite  = actDir;
  assign locWrEn   = beatGo && !actDir;
  assign locRdEn   = actValid && actDir;
  assign locWrData = extRdData;
  assign extWrData = locRdData;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      OFS_EXT:  regRdData = REG_DW'(progExt);
      OFS_LOC:  regRdData = REG_DW'(progLoc);
      OFS_STAT: begin
        regRdData[BIT_BUSY] = actValid || pendValid;
        regRdData[BIT_FULL] = pendValid;
      end
      default:  regRdData = '0;
    endcase
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !extReq |-> !(locWrEn || locRdEn)); // R8
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({locWrEn, locRdEn}) <= 1); // R8
endmodule

// File: tb/test_strided_dma.sv
module test_strided_dma;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        extReq, extWrite, locWrEn, locRdEn;
  logic [31:0] extAddr, locAddr;
  logic        extGrant = 1'b0;
  logic [63:0] extRdData, extWrData, locWrData, locRdData;
  logic [63:0] locMem [64];

  int testCnt = 0, failCnt = 0;
  bit done = 0;
  int grantMode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural model state
  logic [31:0] mProgExt = 0, mProgLoc = 0, mExt = 0, mLoc = 0, mSkip = 0;
  bit mAct = 0, mDir = 0;
  int mBeatsLeft = 0, mRowBeats = 0, mRowsLeft = 0;
  logic [127:0] pendQ[$];

  always #(PERIOD/2) clk = ~clk;

  strided_dma i_strided_dma (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .extReq(extReq),
    .extWrite(extWrite), .extAddr(extAddr), .extGrant(extGrant),
    .extRdData(extRdData), .extWrData(extWrData), .locAddr(locAddr),
    .locWrEn(locWrEn), .locWrData(locWrData), .locRdEn(locRdEn),
    .locRdData(locRdData));

  function automatic logic [63:0] extPattern(input logic [31:0] a);
    return {32'hA5A5_0000 ^ a, a};
  endfunction

  assign extRdData = extPattern(extAddr);
  assign locRdData = locMem[locAddr[8:3]];

  always @(posedge clk) if (locWrEn) locMem[locAddr[8:3]] <= locWrData;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic loadActive(input bit dir, input logic [31:0] e, input logic [31:0] l,
                            input logic [31:0] w);
    mAct = 1; mDir = dir; mExt = e; mLoc = l;
    mRowBeats = int'(w[11:3]) + 1; mBeatsLeft = mRowBeats;
    mRowsLeft = int'(w[19:12]); mSkip = {w[31:23], 3'b000};
  endtask

  // one clock cycle: drive, compare, advance model
  task automatic step(input bit we, input logic [2:0] a, input logic [31:0] d);
    logic [31:0] expRd;
    bit trig, dirN, grantBeat, lastBeat, busyPre;
    regWrEn = we; regAddr = a; regWrData = d;
    extGrant = (grantMode == 0) ? 1'b1 : (grantMode == 1) ? lfsr[0] : 1'b0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #1;
    expRd = 0;
    if (a == 3'd0) expRd = mProgExt;
    else if (a == 3'd1) expRd = mProgLoc;
    else if (a == 3'd4) expRd = {28'd0, pendQ.size() != 0, mAct || pendQ.size() != 0, 2'b00};
    chk((a == 3'd4) ? "R3 status" : "R2 R3 readback", 64'(regRdData), 64'(expRd));
    chk("R5 R12 extReq", 64'(extReq), 64'(mAct));
    if (mAct) begin
      chk("R4 extWrite", 64'(extWrite), 64'(mDir));
      chk("R6 R7 extAddr", 64'(extAddr), 64'(mExt));
      chk("R6 R7 locAddr", 64'(locAddr), 64'(mLoc));
    end
    chk("R8 locWrEn", 64'(locWrEn), 64'(mAct && !mDir && extGrant));
    chk("R8 locRdEn", 64'(locRdEn), 64'(mAct && mDir));
    if (locWrEn) chk("R8 locWrData", locWrData, extRdData);
    if (locRdEn) chk("R8 extWrData", extWrData, locRdData);
    // model update
    trig = we && (a == 3'd2 || a == 3'd3);
    dirN = (a == 3'd3);
    grantBeat = mAct && extGrant;
    lastBeat = grantBeat && mBeatsLeft == 1 && mRowsLeft == 0;
    busyPre = mAct;
    if (trig && (!mAct || lastBeat) && pendQ.size() == 0) begin
      loadActive(dirN, mProgExt, mProgLoc, d);
    end else begin
      if (trig && busyPre && !lastBeat && pendQ.size() == 0)
        pendQ.push_back({31'd0, dirN, mProgExt, mProgLoc, d});
      if (lastBeat && pendQ.size() != 0) begin
        logic [127:0] p;
        p = pendQ.pop_front();
        loadActive(p[96], p[95:64], p[63:32], p[31:0]);
      end else if (lastBeat) begin
        mAct = 0;
      end else if (grantBeat) begin
        if (mBeatsLeft == 1) begin
          mRowsLeft--; mBeatsLeft = mRowBeats;
          mExt = mExt + 8 + mSkip; mLoc = mLoc + 8;
        end else begin
          mBeatsLeft--; mExt = mExt + 8; mLoc = mLoc + 8;
        end
      end
    end
    if (we && a == 3'd0) mProgExt = {d[31:3], 3'b000};
    if (we && a == 3'd1) mProgLoc = {d[31:3], 3'b000};
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400 && (mAct || pendQ.size() != 0); i++) step(0, 3'd4, 0);
    chk("R12 drained", 64'(mAct || pendQ.size() != 0), 64'(0));
  endtask

  initial begin
    for (int i = 0; i < 64; i++) locMem[i] = {32'h1111_0000 + i, 32'h2222_0000 + i};
    #(PERIOD*2 + 2);
    // R1: reset state, sampled while in reset
    chk("R1 extReq", 64'(extReq), 0);
    chk("R1 locWrEn", 64'(locWrEn), 0);
    chk("R1 locRdEn", 64'(locRdEn), 0);
    @(negedge clk);
    rstN = 1'b1;
    for (int a = 0; a < 8; a++) step(0, 3'(a), 0);   // R1 all reads zero
    // R2: address registers with low-bit clearing
    step(1, 3'd0, 32'h0000_1003);
    step(0, 3'd0, 0);
    step(1, 3'd1, 32'h0000_0047);
    step(0, 3'd1, 0);
    // R4 R6 R7: external-to-local, 2 beats/row, 3 rows, skip 0x1F -> 0x18
    grantMode = 0;
    step(1, 3'd2, {12'h01F, 8'd2, 12'h00F});
    waitIdle();
    for (int r = 0; r < 3; r++)
      for (int b = 0; b < 2; b++) begin
        logic [31:0] ea;
        ea = 32'h1000 + 32'(r * (16 + 24) + 8 * b);
        chk("R7 strided landing", locMem[8 + 2*r + b], extPattern(ea));
      end
    // R9 R10 R11: local-to-external with queue and ignored trigger
    step(1, 3'd0, 32'h0000_2000);
    step(1, 3'd1, 32'h0000_0080);
    grantMode = 2;
    step(1, 3'd3, {12'h040, 8'd1, 12'h01F});
    step(1, 3'd0, 32'h0000_3000);
    step(1, 3'd1, 32'h0000_0100);
    step(1, 3'd2, {12'h000, 8'd0, 12'h007});   // queued (R9)
    step(0, 3'd4, 0);                          // full expected
    chk("R9 full seen", 64'(pendQ.size()), 1);
    step(1, 3'd0, 32'h0000_4000);
    step(1, 3'd3, {12'h000, 8'd0, 12'h007});   // ignored (R11)
    step(0, 3'd4, 0);
    grantMode = 1;
    waitIdle();
    step(0, 3'd0, 0);
    // R5: single-beat transfer with length bits 2:0 set (R6)
    grantMode = 0;
    step(1, 3'd1, 32'h0000_0010);
    step(1, 3'd2, {12'h000, 8'd0, 12'h005});
    waitIdle();
    // R10: queue a job exactly behind a long read, full grant
    step(1, 3'd0, 32'h0000_5000);
    step(1, 3'd2, {12'h008, 8'd3, 12'h00F});
    step(1, 3'd0, 32'h0000_6000);
    step(1, 3'd3, {12'h000, 8'd1, 12'h00F});
    waitIdle();
    for (int i = 0; i < 4; i++) step(0, 3'(4 + i), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #(PERIOD * 50000);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule